// File: doc/BRIEF.md
# 64-bit Integer Multiply Unit

This execution unit computes the multiply operations of a 64-bit RISC-V integer core. The issue stage hands it two 64-bit source operands, the instruction's funct3 and funct7 fields, and a flag that says whether the instruction came from the 32-bit word opcode class (OP-32) or the normal register class (OP). One start pulse launches the operation. The result comes back with a single-cycle done strobe.

The unit supports five operations. It returns the wrapped low half of the product. It returns the upper half of the 128-bit product for three operand signedness pairs. It also returns a sign-extended 32-bit word product. Internally it forms the unsigned product of the operand magnitudes over several cycles, adding STEP_BITS partial products per cycle, and negates the result at the end when the signs call for it. A word operation uses only half of the iterations. An encoding the unit does not implement completes at once and is flagged as illegal.

Top module: `mul_unit`

## Requirements
- R1: While rst_ni is low and after its release, busy_o, done_o and illegal_o are 0.
- R2: Encodings with funct7 = 0000001 are decoded as follows. In the OP class (word_i = 0), funct3 000 selects the low product, 001 the signed×signed high half, 010 the signed×unsigned high half, and 011 the unsigned×unsigned high half. In the OP-32 class (word_i = 1), funct3 000 selects the word product.
- R3: The low-product operation returns bits 63:0 of a×b, and overflow wraps silently.
- R4: The signed×signed operation returns bits 127:64 of the product, with both operands taken as two's complement.
- R5: The signed×unsigned operation returns bits 127:64 of the product, with a taken as two's complement and b taken as unsigned.
- R6: The unsigned×unsigned operation returns bits 127:64 of the product of both operands taken as unsigned.
- R7: The word operation multiplies a[31:0] by b[31:0] and ignores the upper operand bits. It returns the 32-bit product in bits 31:0, with bit 31 copied into bits 63:32.
- R8: done_o is high for exactly one cycle. For a 64-bit operation it rises at the 64/STEP_BITS-th clock edge after the edge that accepted start_i. For a word operation it rises at the (64/STEP_BITS)/2-th edge.
- R9: A start_i is accepted only while busy_o is 0. busy_o stays 1 from acceptance through the done cycle. A start_i, operand change or opcode change while busy_o is 1 does not change the pending result and does not create an extra done_o.
- R10: Any other encoding is illegal. This covers funct7 other than 0000001, funct3 1xx in either class, and funct3 other than 000 in OP-32. An illegal encoding raises done_o at the accepting edge itself, with illegal_o = 1 and result_o = 0. illegal_o is never 1 outside done_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Launch request, honoured while idle |
| funct3_i | input | 3 | Instruction funct3 field |
| funct7_i | input | 7 | Instruction funct7 field |
| word_i | input | 1 | 1 = OP-32 class, 0 = OP class |
| op_a_i | input | 64 | First source operand |
| op_b_i | input | 64 | Second source operand |
| busy_o | output | 1 | Operation in flight or completing |
| done_o | output | 1 | One-cycle completion strobe |
| illegal_o | output | 1 | Unimplemented encoding, valid with done_o |
| result_o | output | 64 | Result, valid with done_o |

## Verification
The bench checks every result, the illegal flag and the number of cycles from acceptance to done. A corrupted iteration counter therefore shows up on the first operation as an early or late done_o. A wrong partial-product row, shift or sign fix shows as a wrong result_o on the same done_o. The operand sets include the most negative value, all-ones values and word operands with dirty upper bits, so that each signedness path fails on its own vector. The bench also drives starts while the unit is busy. A capture or state machine fault then shows as a changed result or as a done_o that no queued item expects.

// File: rtl/mul_pkg.sv
package mul_pkg;
  typedef enum logic [2:0] {
    MOP_LO,
    MOP_HI_SS,
    MOP_HI_SU,
    MOP_HI_UU,
    MOP_WORD
  } mop_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RUN,
    ST_DONE
  } mst_e;

  localparam logic [6:0] F7_MULDIV = 7'b0000001;
endpackage

// File: rtl/mul_decode.sv
module mul_decode
  import mul_pkg::*;
(
  input  logic [2:0] funct3_i,
  input  logic [6:0] funct7_i,
  input  logic       word_i,
  output mop_e       op_o,
  output logic       legal_o,
  output logic       a_signed_o,
  output logic       b_signed_o
);
  always_comb begin
    op_o       = MOP_LO;
    legal_o    = 1'b0;
    a_signed_o = 1'b0;
    b_signed_o = 1'b0;
    if (funct7_i == F7_MULDIV) begin
      if (word_i) begin
        if (funct3_i == 3'b000) begin
          op_o    = MOP_WORD;
          legal_o = 1'b1;
        end
      end else begin
        case (funct3_i)
          3'b000: begin op_o = MOP_LO; legal_o = 1'b1; end
          3'b001: begin op_o = MOP_HI_SS; legal_o = 1'b1; a_signed_o = 1'b1; b_signed_o = 1'b1; end
          3'b010: begin op_o = MOP_HI_SU; legal_o = 1'b1; a_signed_o = 1'b1; end
          3'b011: begin op_o = MOP_HI_UU; legal_o = 1'b1; end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/mul_iter.sv
// Unsigned shift-add multiplier retiring STEP_BITS multiplier bits per cycle.
module mul_iter #(
  parameter int XLEN      = 64,
  parameter int STEP_BITS = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              step_i,
  input  logic              half_i,
  input  logic [XLEN-1:0]   a_i,
  input  logic [XLEN-1:0]   b_i,
  output logic [2*XLEN-1:0] acc_o,
  output logic              last_o
);
  localparam int PW    = 2 * XLEN;
  localparam int ITERS = XLEN / STEP_BITS;
  localparam int HALF  = ITERS / 2;
  localparam int CW    = (ITERS > 1) ? $clog2(ITERS) : 1;

  logic [PW-1:0]   a_sh, acc_q, sum;
  logic [XLEN-1:0] b_sh;
  logic [CW-1:0]   cnt_q;
  logic [PW-1:0]   row [STEP_BITS];

  for (genvar j = 0; j < STEP_BITS; j++) begin : g_row
    assign row[j] = b_sh[j] ? (a_sh << j) : '0;
  end

  always_comb begin
    sum = acc_q;
    for (int j = 0; j < STEP_BITS; j++) sum = sum + row[j];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_sh  <= '0;
      b_sh  <= '0;
      acc_q <= '0;
      cnt_q <= '0;
    end else if (load_i) begin
      a_sh  <= {{XLEN{1'b0}}, a_i};
      b_sh  <= b_i;
      acc_q <= '0;
      cnt_q <= half_i ? CW'(HALF - 1) : CW'(ITERS - 1);
    end else if (step_i) begin
      a_sh  <= a_sh << STEP_BITS;
      b_sh  <= b_sh >> STEP_BITS;
      acc_q <= sum;
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign acc_o  = acc_q;
  assign last_o = (cnt_q == '0);

  p_count_down_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
  p_load_excl_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(load_i && step_i));
endmodule

// File: rtl/mul_result.sv
module mul_result
  import mul_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [2*XLEN-1:0] acc_i,
  input  logic              neg_i,
  input  mop_e              op_i,
  input  logic              illegal_i,
  output logic [XLEN-1:0]   res_o
);
  localparam int W = XLEN / 2;

  logic [2*XLEN-1:0] prod;

  always_comb begin
    prod = neg_i ? (~acc_i + (2*XLEN)'(1)) : acc_i;
    if (illegal_i) res_o = '0;
    else begin
      case (op_i)
        MOP_LO:   res_o = prod[XLEN-1:0];
        MOP_WORD: res_o = {{W{prod[W-1]}}, prod[W-1:0]};
        default:  res_o = prod[2*XLEN-1:XLEN];
      endcase
    end
  end
endmodule

// File: rtl/mul_unit.sv
module mul_unit
  import mul_pkg::*;
#(
  parameter int XLEN      = 64,
  parameter int STEP_BITS = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic [2:0]      funct3_i,
  input  logic [6:0]      funct7_i,
  input  logic            word_i,
  input  logic [XLEN-1:0] op_a_i,
  input  logic [XLEN-1:0] op_b_i,
  output logic            busy_o,
  output logic            done_o,
  output logic            illegal_o,
  output logic [XLEN-1:0] result_o
);
  localparam int W = XLEN / 2;

  mst_e state_q;
  mop_e dec_op, op_q;
  logic dec_legal, a_sgn, b_sgn, neg_q, ill_q, accept, load, last;
  logic [XLEN-1:0]   a_ext, b_ext, a_mag, b_mag;
  logic [2*XLEN-1:0] acc;

  mul_decode u_dec (
    .funct3_i  (funct3_i),
    .funct7_i  (funct7_i),
    .word_i    (word_i),
    .op_o      (dec_op),
    .legal_o   (dec_legal),
    .a_signed_o(a_sgn),
    .b_signed_o(b_sgn)
  );

  // word form works on zero-extended low halves; signs only matter for high forms
  assign a_ext  = word_i ? {{W{1'b0}}, op_a_i[W-1:0]} : op_a_i;
  assign b_ext  = word_i ? {{W{1'b0}}, op_b_i[W-1:0]} : op_b_i;
  assign a_mag  = (a_sgn && a_ext[XLEN-1]) ? (~a_ext + XLEN'(1)) : a_ext;
  assign b_mag  = (b_sgn && b_ext[XLEN-1]) ? (~b_ext + XLEN'(1)) : b_ext;
  assign accept = start_i && (state_q == ST_IDLE);
  assign load   = accept && dec_legal;

  mul_iter #(.XLEN(XLEN), .STEP_BITS(STEP_BITS)) u_iter (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(load),
    .step_i(state_q == ST_RUN),
    .half_i(word_i),
    .a_i   (a_mag),
    .b_i   (b_mag),
    .acc_o (acc),
    .last_o(last)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      op_q    <= MOP_LO;
      neg_q   <= 1'b0;
      ill_q   <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: if (accept) begin
          op_q    <= dec_op;
          neg_q   <= (a_sgn & a_ext[XLEN-1]) ^ (b_sgn & b_ext[XLEN-1]);
          ill_q   <= !dec_legal;
          state_q <= dec_legal ? ST_RUN : ST_DONE;
        end
        ST_RUN:  if (last) state_q <= ST_DONE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  mul_result #(.XLEN(XLEN)) u_res (
    .acc_i    (acc),
    .neg_i    (neg_q),
    .op_i     (op_q),
    .illegal_i(ill_q),
    .res_o    (result_o)
  );

  assign busy_o    = (state_q != ST_IDLE);
  assign done_o    = (state_q == ST_DONE);
  assign illegal_o = done_o && ill_q;

  p_done_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_busy_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !done_o) |=> busy_o);
  p_accept_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> busy_o);
  p_illegal_in_done_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> (done_o && result_o == '0));
  p_word_sext_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !illegal_o && op_q == MOP_WORD) |-> (result_o[XLEN-1:W] == {W{result_o[W-1]}}));
endmodule

// File: tb/mul_unit_tb.sv
module mul_unit_tb;
  localparam int CLK_PERIOD = 10;
  localparam int STEP_BITS  = 8;
  localparam int ITERS      = 64 / STEP_BITS;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  funct3 = '0;
  logic [6:0]  funct7 = '0;
  logic        word = 1'b0;
  logic [63:0] op_a = '0, op_b = '0;
  logic        busy, done, illegal;
  logic [63:0] result;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  logic [63:0] exp_res_q [$];
  bit          exp_ill_q [$];
  int          exp_lat_q [$];
  int          acc_cyc_q [$];
  string       tag_q     [$];

  mul_unit #(.XLEN(64), .STEP_BITS(STEP_BITS)) u_dut (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .start_i  (start),
    .funct3_i (funct3),
    .funct7_i (funct7),
    .word_i   (word),
    .op_a_i   (op_a),
    .op_b_i   (op_b),
    .busy_o   (busy),
    .done_o   (done),
    .illegal_o(illegal),
    .result_o (result)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic void model(input logic [2:0] f3, input logic [6:0] f7, input bit w,
                                input logic [63:0] a, input logic [63:0] b,
                                output logic [63:0] r, output bit ill, output int lat);
    logic [127:0] ea, eb, p;
    logic [31:0]  lo;
    ill = !(f7 == 7'b0000001 && (w ? (f3 == 3'b000) : (f3[2] == 1'b0)));
    r = '0;
    lat = 0;
    if (ill) return;
    if (w) begin
      lo  = a[31:0] * b[31:0];
      r   = {{32{lo[31]}}, lo};
      lat = ITERS / 2;
    end else begin
      ea = {64'd0, a};
      eb = {64'd0, b};
      if (f3 == 3'b001 || f3 == 3'b010) ea = {{64{a[63]}}, a};
      if (f3 == 3'b001) eb = {{64{b[63]}}, b};
      p   = ea * eb;
      r   = (f3 == 3'b000) ? p[63:0] : p[127:64];
      lat = ITERS;
    end
  endfunction

  task automatic issue(input string tag, input logic [2:0] f3, input logic [6:0] f7, input bit w,
                       input logic [63:0] a, input logic [63:0] b);
    logic [63:0] r;
    bit ill;
    int lat;
    while (busy) @(negedge clk);
    model(f3, f7, w, a, b, r, ill, lat);
    exp_res_q.push_back(r);
    exp_ill_q.push_back(ill);
    exp_lat_q.push_back(lat);
    acc_cyc_q.push_back(cyc + 1);
    tag_q.push_back(tag);
    funct3 = f3; funct7 = f7; word = w; op_a = a; op_b = b;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  // drive noise into a busy unit: extra starts, new operands and opcodes
  task automatic poke_busy();
    for (int i = 0; i < 3; i++) begin
      start = 1'b1; funct3 = 3'(i); funct7 = 7'b0000001; word = 1'b0;
      op_a = 64'h1111_0000_0000_0000 + 64'(i); op_b = ~op_a;
      @(negedge clk);
    end
    start = 1'b0;
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (exp_res_q.size() == 0) begin
        checks++; fails++;
        $display("FAIL R9 unexpected done: actual=1 expected=0");
      end else begin
        string t;
        int lat;
        t = tag_q.pop_front();
        lat = cyc - acc_cyc_q.pop_front();
        chk(t, "result", result, exp_res_q.pop_front());
        chk(t, "illegal", 64'(illegal), 64'(exp_ill_q.pop_front()));
        chk({t, "/R8"}, "latency", 64'(lat), 64'(exp_lat_q.pop_front()));
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "busy in reset", 64'(busy), 64'd0);
    chk("R1", "done in reset", 64'(done), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "busy after reset", 64'(busy), 64'd0);
    chk("R1", "done after reset", 64'(done), 64'd0);
    chk("R1", "illegal after reset", 64'(illegal), 64'd0);

    // R3 low product
    issue("R3", 3'b000, 7'b0000001, 1'b0, 64'd3, 64'd5);
    issue("R3", 3'b000, 7'b0000001, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF);
    issue("R3", 3'b000, 7'b0000001, 1'b0, 64'h8000_0000_0000_0000, 64'd2);
    issue("R3", 3'b000, 7'b0000001, 1'b0, 64'h0123_4567_89AB_CDEF, 64'hFEDC_BA98_7654_3210);
    // R4 signed x signed high
    issue("R4", 3'b001, 7'b0000001, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF);
    issue("R4", 3'b001, 7'b0000001, 1'b0, 64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000);
    issue("R4", 3'b001, 7'b0000001, 1'b0, 64'hFFFF_FFFF_FFFF_FFFE, 64'd3);
    issue("R4", 3'b001, 7'b0000001, 1'b0, 64'h7FFF_FFFF_FFFF_FFFF, 64'h8000_0000_0000_0000);
    // R5 signed x unsigned high
    issue("R5", 3'b010, 7'b0000001, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF);
    issue("R5", 3'b010, 7'b0000001, 1'b0, 64'h8000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF);
    issue("R5", 3'b010, 7'b0000001, 1'b0, 64'h1234_5678_9ABC_DEF0, 64'hF000_0000_0000_0001);
    // R6 unsigned x unsigned high
    issue("R6", 3'b011, 7'b0000001, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF);
    issue("R6", 3'b011, 7'b0000001, 1'b0, 64'h8000_0000_0000_0000, 64'd4);
    // R7 word form
    issue("R7", 3'b000, 7'b0000001, 1'b1, 64'h0000_0000_7FFF_FFFF, 64'd2);
    issue("R7", 3'b000, 7'b0000001, 1'b1, 64'hDEAD_0000_0000_0003, 64'h1234_0000_0000_0004);
    issue("R7", 3'b000, 7'b0000001, 1'b1, 64'h0000_0001_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF);
    // R2 encodings / R10 illegal
    issue("R2", 3'b011, 7'b0000001, 1'b0, 64'd7, 64'd9);
    issue("R10", 3'b000, 7'b0000000, 1'b0, 64'd7, 64'd9);
    issue("R10", 3'b100, 7'b0000001, 1'b0, 64'd7, 64'd9);
    issue("R10", 3'b001, 7'b0000001, 1'b1, 64'd7, 64'd9);
    issue("R10", 3'b111, 7'b0000001, 1'b1, 64'd7, 64'd9);
    // R9 starts and input changes while busy
    issue("R9", 3'b011, 7'b0000001, 1'b0, 64'hFFFF_FFFF_0000_0001, 64'hFFFF_FFFF_FFFF_FFFF);
    poke_busy();
    issue("R9", 3'b000, 7'b0000001, 1'b1, 64'h0000_0000_8000_0001, 64'h0000_0000_0000_0003);
    poke_busy();
    issue("R3", 3'b000, 7'b0000001, 1'b0, 64'd11, 64'd13);

    while (busy || exp_res_q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
    chk("R9", "pending items", 64'(exp_res_q.size()), 64'd0);
    chk("R8", "done idle", 64'(done), 64'd0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule